// File: doc/BRIEF.md
# Signed-Count Word Rotator

This unit rotates a 36-bit data word by a signed amount that it takes from an 18-bit address operand. A non-negative count turns the word to the left and a negative count turns it to the right. Every bit that leaves one end of the word re-enters at the other end, so no bits are lost. The count is a 9-bit two's-complement value, so it spans -256 to +255. The count -256 is not dropped to zero: it turns the word 256 places to the right.

A caller places a word and an operand on the inputs and raises `in_valid` for one cycle. One clock later the rotated word appears on `out_word` with `out_valid` high. Inside, the count is turned into a single left-rotate amount in the range 0..35, and a log-depth barrel rotator of six stages (1, 2, 4, 8, 16, 32) applies it.

The output stage is a two-state machine. The state is `OUT_EMPTY` after reset or after a cycle with no input. The state is `OUT_FULL` after a cycle in which `in_valid` was high. The transitions are:
- `OUT_EMPTY` to `OUT_FULL` when an input is accepted.
- `OUT_FULL` to `OUT_EMPTY` when no input is accepted.
- `OUT_FULL` stays in `OUT_FULL` when the next input is accepted.
- `OUT_EMPTY` stays in `OUT_EMPTY` when there is still no input.

Reset forces `OUT_EMPTY`.

Top module: `rot_unit`

## Requirements
- R1: When operand bit 17 is 0, the count is the value of operand bits 7:0 (0..255), and the word is rotated left by that count modulo 36.
- R2: When operand bit 17 is 1, the count is the negative value given by the 9-bit two's-complement number {bit 17, bits 7:0}, and the word is rotated right by the count's magnitude modulo 36.
- R3: Operand bits 16:8 have no effect on the result.
- R4: An operand with bit 17 set to 1 and bits 7:0 all zero means -256. It rotates the word right by 256 positions, which gives the same result as a right rotate by 4. It must not give the input word unchanged.
- R5: `out_valid` is high in the cycle after a cycle in which `in_valid` was high. It is low in the cycle after a cycle in which `in_valid` was low.
- R6: A synchronous active-high reset sets `out_valid` to 0 and `out_word` to 0.
- R7: `out_word` keeps its value through any cycle in which `in_valid` is low.
- R8: The counts 0, +36 and -36 return the input word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The word and count on the inputs are accepted this cycle |
| in_word | input | 36 | Word to rotate |
| in_count | input | 18 | Address operand that carries the signed count |
| out_valid | output | 1 | A result is present on `out_word` |
| out_word | output | 36 | Rotated word, registered |

## Verification
A wrong internal value shows at the ports one cycle after the input is accepted, because there is only one register between input and output. A fault in the count reduction gives a word rotated by the wrong amount or in the wrong direction. Such a fault can hit only a few counts: for example, -256 collapsing to zero, or a multiple of 36 that does not wrap. So every one of the 512 count values is applied, each with random data whose set bits show the amount. A stuck barrel stage shows up as a wrong result on every count that uses that stage. A wrong output state shows up as `out_valid` high or low in the wrong cycle.

// File: rtl/rot_pkg.sv
package rot_pkg;
    parameter int WORD_W = 36;
    parameter int OPD_W  = 18;
    parameter int LOW_W  = 8;

    localparam int MAG_W = LOW_W + 1;
    localparam int AMT_W = $clog2(WORD_W);

    typedef enum logic {
        OUT_EMPTY = 1'b0,
        OUT_FULL  = 1'b1
    } out_state_e;
endpackage

// File: rtl/rot_count_decode.sv
module rot_count_decode
    import rot_pkg::*;
#(
    parameter int W   = WORD_W,
    parameter int OW  = OPD_W,
    parameter int LW  = LOW_W,
    localparam int MW = LW + 1,
    localparam int AW = $clog2(W)
) (
    input  logic [OW-1:0] operand,
    output logic [AW-1:0] left_amt
);
    logic          neg;
    logic [LW-1:0] low;
    logic [MW-1:0] signed_cnt;
    logic [MW-1:0] mag;
    logic [MW-1:0] mag_mod;
    logic [AW-1:0] red;

    always_comb begin
        neg        = operand[OW-1];
        low        = operand[LW-1:0];
        signed_cnt = {neg, low};
        // magnitude of the 9-bit two's-complement value; -256 yields 256
        mag        = neg ? (~signed_cnt + MW'(1)) : signed_cnt;
        mag_mod    = mag % MW'(W);
        red        = mag_mod[AW-1:0];
        if (!neg || red == '0)
            left_amt = red;
        else
            left_amt = AW'(W) - red;
    end

    always_comb begin
        AST_AMT_IN_RANGE: assert (int'(left_amt) < W) // R2
            else $error("left amount out of range");
    end
endmodule

// File: rtl/rot_barrel.sv
module rot_barrel
    import rot_pkg::*;
#(
    parameter int W   = WORD_W,
    localparam int AW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stage [AW+1];

    assign stage[0] = din;

    for (genvar s = 0; s < AW; s++) begin : g_stage
        localparam int SH = 1 << s;
        logic [W-1:0] turned;
        assign turned       = (stage[s] << SH) | (stage[s] >> (W - SH));
        assign stage[s + 1] = amt[s] ? turned : stage[s];
    end

    assign dout = stage[AW];

    always_comb begin
        AST_BITS_KEPT: assert ($countones(dout) == $countones(din)) // R1
            else $error("rotation changed the number of set bits");
        AST_ZERO_PASS: assert (amt != '0 || dout == din) // R8
            else $error("zero amount altered the word");
    end
endmodule

// File: rtl/rot_unit.sv
module rot_unit
    import rot_pkg::*;
#(
    parameter int W   = WORD_W,
    parameter int OW  = OPD_W,
    parameter int LW  = LOW_W,
    localparam int AW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [W-1:0]  in_word,
    input  logic [OW-1:0] in_count,
    output logic          out_valid,
    output logic [W-1:0]  out_word
);
    logic [AW-1:0] left_amt;
    logic [W-1:0]  rotated;
    out_state_e    state_q;
    out_state_e    state_d;

    rot_count_decode #(.W(W), .OW(OW), .LW(LW)) u_dec (
        .operand  (in_count),
        .left_amt (left_amt)
    );

    rot_barrel #(.W(W)) u_bar (
        .din  (in_word),
        .amt  (left_amt),
        .dout (rotated)
    );

    always_comb begin
        unique case (state_q)
            OUT_EMPTY: state_d = in_valid ? OUT_FULL : OUT_EMPTY;
            OUT_FULL:  state_d = in_valid ? OUT_FULL : OUT_EMPTY;
            default:   state_d = OUT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= OUT_EMPTY;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)           out_word <= '0;
        else if (in_valid) out_word <= rotated;
    end

    always_comb begin
        unique case (state_q)
            OUT_FULL:  out_valid = 1'b1;
            default:   out_valid = 1'b0;
        endcase
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid) else $error("valid lost"); // R5
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid) else $error("spurious valid"); // R5
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_word)) else $error("word moved while idle"); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && out_word == '0)) else $error("reset left state"); // R6
endmodule

// File: tb/tb_rot_unit.sv
module tb_rot_unit;
    localparam int W  = 36;
    localparam int OW = 18;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [W-1:0]  in_word;
    logic [OW-1:0] in_count;
    logic          out_valid;
    logic [W-1:0]  out_word;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    logic [W-1:0] held;

    always #5 clk = ~clk;

    rot_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .in_count(in_count), .out_valid(out_valid), .out_word(out_word)
    );

    function automatic logic [W-1:0] ref_rot(logic [W-1:0] w, logic [OW-1:0] c);
        int cnt;
        logic [W-1:0] r;
        cnt = c[OW-1] ? int'(c[7:0]) - 256 : int'(c[7:0]);
        r = w;
        if (cnt >= 0) begin
            for (int i = 0; i < cnt; i++) r = {r[W-2:0], r[W-1]};
        end else begin
            for (int i = 0; i < -cnt; i++) r = {r[0], r[W-1:1]};
        end
        return r;
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive at negedge, sample one negedge after the capturing posedge
    task automatic step(logic v, logic [W-1:0] w, logic [OW-1:0] c, string req);
        logic [W-1:0] exp_w;
        in_valid = v; in_word = w; in_count = c;
        exp_w = v ? ref_rot(w, c) : held;
        @(posedge clk);
        @(negedge clk);
        check({req, " valid"}, W'(out_valid), W'(v));
        check(req, out_word, exp_w);
        held = exp_w;
    endtask

    function automatic logic [OW-1:0] mk(int cnt, logic [8:0] junk);
        logic [8:0] v9;
        v9 = 9'(cnt);
        return {v9[8], junk, v9[7:0]};
    endfunction

    initial begin
        logic [W-1:0] pat;
        rst = 1'b1; in_valid = 1'b0; in_word = '0; in_count = '0;
        held = '0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        check("R6 valid", W'(out_valid), '0);
        check("R6 word", out_word, '0);

        pat = 36'h8_0000_0001;
        step(1'b1, pat, mk(-256, 9'h000), "R4 -256");
        check("R4 equals right 4", out_word, 36'h1_8000_0000);
        step(1'b1, pat, mk(255, 9'h000), "R1 +255");
        step(1'b1, pat, mk(-1, 9'h000), "R2 -1");
        check("R2 -1 value", out_word, 36'hC_0000_0000);
        step(1'b1, 36'h1_2345_6789, mk(0, 9'h000), "R8 zero");
        check("R8 zero value", out_word, 36'h1_2345_6789);
        step(1'b1, 36'h1_2345_6789, mk(36, 9'h000), "R8 +36");
        check("R8 +36 value", out_word, 36'h1_2345_6789);
        step(1'b1, 36'h1_2345_6789, mk(-36, 9'h000), "R8 -36");
        check("R8 -36 value", out_word, 36'h1_2345_6789);
        step(1'b1, 36'h0_0000_0001, mk(1, 9'h1FF), "R3 high junk");
        check("R3 value", out_word, 36'h0_0000_0002);
        step(1'b0, 36'hF_FFFF_FFFF, mk(5, 9'h000), "R7 idle hold");
        step(1'b0, 36'h0_0000_0000, mk(-7, 9'h000), "R5 idle low");

        for (int c = -256; c < 256; c++) begin
            logic [W-1:0] d;
            d = {$urandom(), $urandom()};
            step(1'b1, d, mk(c, 9'($urandom())), c < 0 ? "R2 sweep" : "R1 sweep");
            if ((c & 15) == 0) step(1'b0, ~d, mk(c, 9'h0), "R7 sweep idle");
        end

        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        check("R6 late valid", W'(out_valid), '0);
        check("R6 late word", out_word, '0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule